// File: doc/BRIEF.md
# Times-Three Multiple Generator

This block forms three times an unsigned multiplicand in a single combinational pass. It is meant to feed the hard multiple of a radix-8 recoded multiplier array, where every partial-product row waits on it, so its depth matters more than its area. The product is built as the sum of the operand and the operand moved one place up. The summing adder is split into equal chunks. Each chunk resolves its own carries with a Kogge-Stone prefix network and prepares two candidate sums. A second prefix network of the same shape treats every chunk as a single bit and yields the carry into each chunk. That carry then picks one of the two candidates.

The lowest chunk never receives a carry, so it forms its sum bits directly from its internal carries and has no selection stage. The output is five bits wider than the input. The carry out of the top chunk and the top input bit fill the two lowest extension bits. The remaining extension bits stay zero, because three times any input of N bits is below 2^(N+2). Chunk width, chunk count and extension width are parameters; the defaults give a 64-bit input and a 69-bit output.

Top module: `x3_multiple_gen`

## Requirements
- R1: `triple` equals 3 × `multiplicand` exactly, as an unsigned value of CHUNK_W·NUM_CHUNKS+EXT_W bits, for every input value.
- R2: The output bits at positions IN_W+2 and above are always 0.
- R3: `triple[0]` always equals `multiplicand[0]`, since the lowest chunk takes no carry-in.
- R4: A carry generated in the lowest chunk crosses every higher chunk boundary. For example, input 0x5555_5555_5555_5556 gives 0x1_0000_0000_0000_0002, and 0x5555_5555_5555_5555 gives 0x0_FFFF_FFFF_FFFF_FFFF.
- R5: Bits IN_W+1 and IN_W (bits 65 and 64 by default) are the sum of the top input bit and the carry out of the top chunk. If the top input bit is 1, they are not both 0. If it is 0, bit IN_W+1 is 0. All-ones gives 2'b10 there, and 2^63 gives 2'b01.
- R6: The block holds no state. A change on `multiplicand` shows up on `triple` within the same clock period, with no clock edge in between.
- R7: Each single-bit input 1<<k (k = 0..IN_W-1) gives the output 3<<k.
- R8: Other parameter choices stay correct. With CHUNK_W=2 and NUM_CHUNKS=4 (an 8-bit input and a 13-bit output), all 256 inputs give 3 × input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| multiplicand | input | CHUNK_W·NUM_CHUNKS (64) | Unsigned operand |
| triple | output | CHUNK_W·NUM_CHUNKS+EXT_W (69) | Three times the operand |

## Verification
Two functions can land on the same output bits in one evaluation. The first is the carry produced inside a chunk by its own prefix network. The second is the chunk-level carry-in that swaps the chunk's candidate sum. Patterns such as 0x5555…5556 and all-ones make both act at once, and so do random operands and the exhaustive sweep of the small configuration. Each result is judged against 3 × input, computed arithmetically at full output width.

// File: rtl/x3_pkg.sv
package x3_pkg;

    // Propagate/generate pair for a range of columns (p is the upper bit).
    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    // Combine an upper range with the range directly below it.
    function automatic pg_t pg_merge(pg_t hi, pg_t lo);
        pg_t r;
        r.p = hi.p & lo.p;
        r.g = hi.g | (hi.p & lo.g);
        return r;
    endfunction

endpackage

// File: rtl/x3_prefix_net.sv
module x3_prefix_net
    import x3_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] bit_p,
    input  logic [W-1:0] bit_g,
    output logic [W-1:0] grp_p,
    output logic [W-1:0] grp_g
);
    localparam int LVL = $clog2(W);

    // Row k holds the group terms covering 2^k columns below each position.
    logic [LVL:0][W-1:0] row_p;
    logic [LVL:0][W-1:0] row_g;

    assign row_p[0] = bit_p;
    assign row_g[0] = bit_g;

    genvar k, i;
    generate
        for (k = 0; k < LVL; k++) begin : g_level
            localparam int SPAN = 1 << k;
            for (i = 0; i < W; i++) begin : g_col
                if (i >= SPAN) begin : g_merge
                    assign {row_p[k+1][i], row_g[k+1][i]} =
                        pg_merge(pg_t'({row_p[k][i], row_g[k][i]}),
                                 pg_t'({row_p[k][i-SPAN], row_g[k][i-SPAN]}));
                end else begin : g_pass
                    assign row_p[k+1][i] = row_p[k][i];
                    assign row_g[k+1][i] = row_g[k][i];
                end
            end
        end
    endgenerate

    assign grp_p = row_p[LVL];
    assign grp_g = row_g[LVL];

endmodule

// File: rtl/x3_chunk.sv
module x3_chunk #(
    parameter int W      = 8,
    parameter bit SELECT = 1'b1
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         blk_p,
    output logic         blk_g
);
    logic [W-1:0] col_p, col_g, half;
    logic [W-1:0] grp_p, grp_g;
    logic [W-1:0] carry0;

    assign col_g = op_a & op_b;
    assign col_p = op_a | op_b;   // inclusive OR
    assign half  = op_a ^ op_b;

    x3_prefix_net #(.W(W)) u_pfx (
        .bit_p (col_p),
        .bit_g (col_g),
        .grp_p (grp_p),
        .grp_g (grp_g)
    );

    // Carries into each column assuming a chunk carry-in of 0.
    assign carry0 = {grp_g[W-2:0], 1'b0};
    assign blk_p  = grp_p[W-1];
    assign blk_g  = grp_g[W-1];

    generate
        if (SELECT) begin : g_select
            logic [W-1:0] carry1, sum0, sum1;
            // Carries into each column assuming a chunk carry-in of 1.
            assign carry1 = {grp_g[W-2:0] | grp_p[W-2:0], 1'b1};
            assign sum0   = half ^ carry0;
            assign sum1   = half ^ carry1;
            assign sum    = cin ? sum1 : sum0;
        end else begin : g_base
            logic unused_base;
            assign unused_base = cin ^ (^grp_p[W-2:0]);
            assign sum = half ^ carry0;
        end
    endgenerate

endmodule

// File: rtl/x3_multiple_gen.sv
module x3_multiple_gen #(
    parameter int CHUNK_W    = 8,
    parameter int NUM_CHUNKS = 8,
    parameter int EXT_W      = 5
) (
    input  logic [CHUNK_W*NUM_CHUNKS-1:0]       multiplicand,
    output logic [CHUNK_W*NUM_CHUNKS+EXT_W-1:0] triple
);
    localparam int IN_W  = CHUNK_W * NUM_CHUNKS;
    localparam int OUT_W = IN_W + EXT_W;

    logic [IN_W-1:0]       op_a, op_b;
    logic [NUM_CHUNKS-1:0] chk_p, chk_g;
    logic [NUM_CHUNKS-1:0] span_p, span_g;
    logic [NUM_CHUNKS-1:0] chk_cin;
    logic                  top_cout;

    // Each input bit feeds its own column and the column above it.
    assign op_a = multiplicand;
    assign op_b = {multiplicand[IN_W-2:0], 1'b0};

    assign chk_cin = {span_g[NUM_CHUNKS-2:0], 1'b0};

    genvar j;
    generate
        for (j = 0; j < NUM_CHUNKS; j++) begin : g_chunk
            x3_chunk #(
                .W      (CHUNK_W),
                .SELECT (j != 0)
            ) u_chunk (
                .op_a  (op_a[j*CHUNK_W +: CHUNK_W]),
                .op_b  (op_b[j*CHUNK_W +: CHUNK_W]),
                .cin   (chk_cin[j]),
                .sum   (triple[j*CHUNK_W +: CHUNK_W]),
                .blk_p (chk_p[j]),
                .blk_g (chk_g[j])
            );
        end
    endgenerate

    // Second level: one column per chunk.
    x3_prefix_net #(.W(NUM_CHUNKS)) u_span (
        .bit_p (chk_p),
        .bit_g (chk_g),
        .grp_p (span_p),
        .grp_g (span_g)
    );

    logic unused_span;
    assign unused_span = ^span_p;

    assign top_cout = span_g[NUM_CHUNKS-1];

    // Extension columns: shifted top bit plus the carry out of the top chunk.
    assign triple[IN_W]             = multiplicand[IN_W-1] ^ top_cout;
    assign triple[IN_W+1]           = multiplicand[IN_W-1] & top_cout;
    assign triple[OUT_W-1:IN_W+2]   = '0;

endmodule

// File: rtl/x3_multiple_gen_checker.sv
module x3_multiple_gen_checker #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 69
) (
    input logic [IN_W-1:0]  multiplicand,
    input logic [OUT_W-1:0] triple
);
    logic [OUT_W-1:0] wide_x;
    assign wide_x = OUT_W'(multiplicand);

    always_comb begin
        p_triple_r1: assert (triple == (wide_x << 1) + wide_x)
            else $error("R1 triple mismatch");
        p_top_zero_r2: assert (triple[OUT_W-1:IN_W+2] == '0)
            else $error("R2 high extension bits not zero");
        p_lsb_r3: assert (triple[0] == multiplicand[0])
            else $error("R3 lowest bit mismatch");
        p_no_wrap_r4: assert (triple >= wide_x)
            else $error("R4 result below operand");
        if (multiplicand[IN_W-1]) begin
            p_ext_set_r5: assert (triple[IN_W+1:IN_W] != 2'b00)
                else $error("R5 extension bits empty with top bit set");
        end else begin
            p_ext_clr_r5: assert (triple[IN_W+1] == 1'b0)
                else $error("R5 extension bit set with top bit clear");
        end
    end

endmodule

bind x3_multiple_gen x3_multiple_gen_checker #(
    .IN_W  (CHUNK_W*NUM_CHUNKS),
    .OUT_W (CHUNK_W*NUM_CHUNKS+EXT_W)
) u_chk (
    .multiplicand (multiplicand),
    .triple       (triple)
);

// File: tb/x3_multiple_gen_bench.sv
module x3_multiple_gen_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int n_checks = 0;
    int n_fail   = 0;

    logic [63:0] x_big;
    logic [68:0] y_big;
    logic [7:0]  x_small;
    logic [12:0] y_small;

    x3_multiple_gen u_x3_multiple_gen (
        .multiplicand (x_big),
        .triple       (y_big)
    );

    x3_multiple_gen #(
        .CHUNK_W    (2),
        .NUM_CHUNKS (4),
        .EXT_W      (5)
    ) u_x3_multiple_gen_small (
        .multiplicand (x_small),
        .triple       (y_small)
    );

    task automatic check_big(input logic [63:0] x, input string req);
        logic [68:0] exp;
        @(negedge clk);
        x_big = x;
        #1;
        exp = 69'(x) * 69'd3;
        n_checks++;
        if (y_big !== exp) begin
            n_fail++;
            $display("FAIL %s x=%h actual=%h expected=%h", req, x, y_big, exp);
        end
    endtask

    task automatic check_field(input logic [68:0] act, input logic [68:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        x_big   = '0;
        x_small = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Initial state: zero operand gives zero (R1)
        check_big(64'd0, "R1 zero");

        // All-ones: R1 and extension bits 65:64 == 2'b10 (R5)
        check_big({64{1'b1}}, "R1 all-ones");
        check_field(69'(y_big[65:64]), 69'd2, "R5 all-ones ext");
        check_field(69'(y_big[68:66]), 69'd0, "R2 all-ones top");

        // Top bit alone: ext bits == 2'b01 (R5)
        check_big(64'h8000_0000_0000_0000, "R5 msb");
        check_field(69'(y_big[65:64]), 69'd1, "R5 msb ext");

        // Alternating patterns and long carry chains across chunks (R4)
        check_big(64'h5555_5555_5555_5555, "R4 fives");
        check_field(y_big, 69'h0_FFFF_FFFF_FFFF_FFFF, "R4 fives literal");
        check_big(64'h5555_5555_5555_5556, "R4 fives plus one");
        check_field(y_big, 69'h1_0000_0000_0000_0002, "R4 ripple literal");
        check_big(64'hAAAA_AAAA_AAAA_AAAA, "R1 alternating a");
        check_big(64'h00FF_00FF_00FF_00FF, "R4 chunk stripes");

        // Lowest bit follows input (R3)
        check_big(64'h1234_5678_9ABC_DEF1, "R3 odd");
        check_field(69'(y_big[0]), 69'd1, "R3 odd lsb");
        check_big(64'h1234_5678_9ABC_DEF0, "R3 even");
        check_field(69'(y_big[0]), 69'd0, "R3 even lsb");

        // Single bits (R7)
        for (int k = 0; k < 64; k++) begin
            check_big(64'd1 << k, "R7 single bit");
        end

        // Same-period response with no clock edge in between (R6)
        @(negedge clk);
        x_big = 64'd7;
        #1;
        x_big = 64'hFFFF_0000_FFFF_0000;
        #1;
        check_field(y_big, 69'(64'hFFFF_0000_FFFF_0000) * 69'd3, "R6 same period");

        // Random operands (R1, R2)
        for (int n = 0; n < 400; n++) begin
            check_big({$urandom(), $urandom()}, "R1 random");
            check_field(69'(y_big[68:66]), 69'd0, "R2 random top");
        end

        // Exhaustive sweep of the small configuration (R8)
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            x_small = 8'(v);
            #1;
            n_checks++;
            if (y_small !== 13'(v * 3)) begin
                n_fail++;
                $display("FAIL R8 x=%0d actual=%0d expected=%0d", v, y_small, v * 3);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule